// File: doc/BRIEF.md
# Descriptor-Chained Source Streamer

This block walks a chain of in-memory descriptors and streams the source bytes each one names out to a hash core. A descriptor gives a source address, a byte length, a pointer to the next descriptor, a set of chunk markers for the hash core and a control word. The engine reads the descriptor, fetches the source data one 32-bit word at a time over a simple request/valid memory read port, and offers each word on a valid/ready output. The chunk markers of the current descriptor travel alongside every word.

When an item's data has been consumed, the engine raises a completion pulse. An empty item raises a separate empty-item pulse instead. The control word then decides what happens next. The engine may go idle, follow the next pointer at once, or park until a restart command arrives. A restart re-reads the descriptor at the parked item's next pointer. That pointer may point back at the same descriptor, so software can rewrite the descriptor in place and continue the same message.

Software sets the chain head on the base address input and pulses the start command. Descriptors and source buffers sit on 8-byte boundaries. Every item except the final one of a message carries a multiple of 64 bytes.

Top module: `lldma_src_fetch`

## Requirements
- R1: After reset the engine is idle: busy, paused, mem_rd_req, out_valid and both event outputs are low.
- R2: A descriptor is six 32-bit words at byte offsets 0,4,8,12,16,20 from its address, read in that order. The words are: source address, length in bytes, marker word, an unused word, next-descriptor address, and control word. Marker word bit 0 is string-start, bit 1 is cipher-start and bit 2 is string-last. Control word bit 0 is item-done-enable, bit 1 is end-of-chain and bit 2 is pause. All other bits are ignored.
- R3: An item of length L yields ceil(L/4) output words. Word w is the memory word at source address + 4w. out_last is high on the final word only. out_nbytes is 4 on every word except the final one, where it is L mod 4, or 4 when L mod 4 is 0. A word held while out_ready is low keeps out_data, out_last and out_nbytes unchanged.
- R4: The three marker bits of the current descriptor are presented on sb_str_start, sb_cipher_start and sb_str_last with every output word of that item.
- R5: evt_item_done pulses for exactly one cycle. It is high in the cycle right after the handshake of an item's final word, and only when that item's item-done-enable bit is set and its length is non-zero.
- R6: An item of length 0 produces no output word and no evt_item_done. It produces one evt_zero_len pulse instead.
- R7: After an item whose end-of-chain bit is set, the engine returns to idle and issues no further memory reads.
- R8: After an item with neither end-of-chain nor pause set, the engine fetches the next descriptor from the item's next address without any command.
- R9: After an item with pause set and end-of-chain clear, paused goes high. The engine then issues no reads and emits no words until cmd_restart. On cmd_restart it fetches the descriptor at that item's next address.
- R10: cmd_start is accepted only while idle. cmd_restart is accepted only while paused. At any other time each has no effect.
- R11: Once mem_rd_req is raised, it and mem_rd_addr stay unchanged until a cycle with mem_rd_valid high, which completes the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Begin a new message at base_addr |
| cmd_restart | input | 1 | Continue a paused message |
| base_addr | input | ADDR_W | First descriptor address |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_valid | input | 1 | Read data valid, completes the request |
| mem_rd_data | input | 32 | Read data word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Hash core accepts the word |
| out_data | output | 32 | Output data word |
| out_last | output | 1 | Final word of the item |
| out_nbytes | output | 3 | Valid bytes in the word (1 to 4) |
| sb_str_start | output | 1 | String-start marker of the current item |
| sb_cipher_start | output | 1 | Cipher-start marker of the current item |
| sb_str_last | output | 1 | String-last marker of the current item |
| evt_item_done | output | 1 | Item-completion pulse |
| evt_zero_len | output | 1 | Empty-item pulse |
| busy | output | 1 | Engine is fetching or streaming |
| paused | output | 1 | Engine waits for cmd_restart |

## Verification
A read that completes at a clock edge shows up on out_valid in the next cycle. An item's event is due one cycle after the handshake of its final word. The engine leaves busy one cycle after that event, so a check must not look at busy in the same cycle as the event. The bench samples every output on the falling edge. It records a handshake whenever out_valid and out_ready are both high at that sample. It accepts an evt_item_done pulse only if the previous sample recorded a handshake on a final word. Memory latency and out_ready stalls are randomized, so the stream and event counts are compared against bench-built queues only after the engine has gone idle and three more cycles have passed.

// File: rtl/lldma_pkg.sv
`timescale 1ns/1ps
package lldma_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 6;
  localparam int IDX_W      = 3;
  // word positions inside a descriptor, in fetch order
  localparam int W_SRC  = 0;
  localparam int W_LEN  = 1;
  localparam int W_USER = 2;
  localparam int W_NEXT = 4;
  localparam int W_CTRL = 5;
  // control word bits
  localparam int CB_DONE_EN = 0;
  localparam int CB_LAST    = 1;
  localparam int CB_PAUSE   = 2;
  // marker word bits
  localparam int UB_STR_START  = 0;
  localparam int UB_CIPH_START = 1;
  localparam int UB_STR_LAST   = 2;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] len;
    logic [WORD_W-1:0] next;
    logic [2:0]        user;
    logic [2:0]        ctrl;
  } desc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC, ST_RD, ST_OUT, ST_FIN, ST_PAUSE
  } st_t;

  // number of 32-bit words covering len bytes
  function automatic logic [WORD_W-1:0] beat_count(input logic [WORD_W-1:0] len);
    return (len >> 2) + {{(WORD_W-1){1'b0}}, |len[1:0]};
  endfunction

  // valid bytes in the final word of an item
  function automatic logic [2:0] tail_bytes(input logic [WORD_W-1:0] len);
    return (len[1:0] == 2'b00) ? 3'd4 : {1'b0, len[1:0]};
  endfunction

  // byte offset of word n
  function automatic logic [WORD_W-1:0] word_off(input logic [WORD_W-1:0] n);
    return n << 2;
  endfunction
endpackage

// File: rtl/lldma_desc_store.sv
`timescale 1ns/1ps
module lldma_desc_store
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output desc_t             desc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc <= '0;
    end else if (wr_en) begin
      unique case (wr_idx)
        IDX_W'(W_SRC):  desc.src  <= wr_data;
        IDX_W'(W_LEN):  desc.len  <= wr_data;
        IDX_W'(W_USER): desc.user <= wr_data[2:0];
        IDX_W'(W_NEXT): desc.next <= wr_data;
        IDX_W'(W_CTRL): desc.ctrl <= wr_data[2:0];
        default: ;  // unused word
      endcase
    end
  end

  a_r2_word_index: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(DESC_WORDS)));
endmodule

// File: rtl/lldma_beat_ctr.sv
`timescale 1ns/1ps
module lldma_beat_ctr
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] len,
  input  logic              adv,
  output logic [WORD_W-1:0] idx,
  output logic              last_beat,
  output logic              empty,
  output logic [2:0]        nbytes
);
  logic [WORD_W-1:0] total;
  logic [2:0]        tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total  <= '0;
      idx    <= '0;
      tail_q <= 3'd4;
    end else if (load) begin
      total  <= beat_count(len);
      idx    <= '0;
      tail_q <= tail_bytes(len);
    end else if (adv) begin
      idx <= idx + WORD_W'(1);
    end
  end

  assign empty     = (total == '0);
  assign last_beat = (idx + WORD_W'(1) == total);
  assign nbytes    = last_beat ? tail_q : 3'd4;

  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (idx < total));
endmodule

// File: rtl/lldma_src_fetch.sv
`timescale 1ns/1ps
module lldma_src_fetch
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_restart,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic [2:0]        out_nbytes,
  output logic              sb_str_start,
  output logic              sb_cipher_start,
  output logic              sb_str_last,
  output logic              evt_item_done,
  output logic              evt_zero_len,
  output logic              busy,
  output logic              paused
);
  st_t               st;
  logic [ADDR_W-1:0] desc_ptr;
  logic [IDX_W-1:0]  wcnt;
  logic [WORD_W-1:0] out_q;
  desc_t             desc;

  // named internal events
  logic              rd_fire, out_fire, desc_wr, desc_done;
  logic              ctr_adv, ctr_last, ctr_empty;
  logic [WORD_W-1:0] ctr_idx;
  logic [2:0]        ctr_nbytes;

  assign rd_fire   = mem_rd_req && mem_rd_valid;
  assign out_fire  = out_valid && out_ready;
  assign desc_wr   = (st == ST_DESC) && rd_fire;
  assign desc_done = desc_wr && (wcnt == IDX_W'(DESC_WORDS-1));
  assign ctr_adv   = out_fire && !ctr_last;

  lldma_desc_store u_desc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (desc_wr),
    .wr_idx  (wcnt),
    .wr_data (mem_rd_data),
    .desc    (desc)
  );

  lldma_beat_ctr u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (desc_done),
    .len       (desc.len),
    .adv       (ctr_adv),
    .idx       (ctr_idx),
    .last_beat (ctr_last),
    .empty     (ctr_empty),
    .nbytes    (ctr_nbytes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      desc_ptr <= '0;
      wcnt     <= '0;
      out_q    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (cmd_start) begin
          desc_ptr <= base_addr;
          wcnt     <= '0;
          st       <= ST_DESC;
        end
        ST_DESC: if (rd_fire) begin
          if (wcnt == IDX_W'(DESC_WORDS-1)) begin
            wcnt <= '0;
            st   <= (desc.len == '0) ? ST_FIN : ST_RD;
          end else begin
            wcnt <= wcnt + IDX_W'(1);
          end
        end
        ST_RD: if (rd_fire) begin
          out_q <= mem_rd_data;
          st    <= ST_OUT;
        end
        ST_OUT: if (out_fire) st <= ctr_last ? ST_FIN : ST_RD;
        ST_FIN: begin
          if (desc.ctrl[CB_LAST]) begin
            st <= ST_IDLE;
          end else if (desc.ctrl[CB_PAUSE]) begin
            st <= ST_PAUSE;
          end else begin
            desc_ptr <= ADDR_W'(desc.next);
            st       <= ST_DESC;
          end
        end
        ST_PAUSE: if (cmd_restart) begin
          desc_ptr <= ADDR_W'(desc.next);
          wcnt     <= '0;
          st       <= ST_DESC;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (st == ST_DESC) mem_rd_addr = desc_ptr + ADDR_W'(word_off(WORD_W'(wcnt)));
    else               mem_rd_addr = ADDR_W'(desc.src + word_off(ctr_idx));
  end

  assign mem_rd_req      = (st == ST_DESC) || (st == ST_RD);
  assign out_valid       = (st == ST_OUT);
  assign out_data        = out_q;
  assign out_last        = out_valid && ctr_last;
  assign out_nbytes      = ctr_nbytes;
  assign sb_str_start    = out_valid && desc.user[UB_STR_START];
  assign sb_cipher_start = out_valid && desc.user[UB_CIPH_START];
  assign sb_str_last     = out_valid && desc.user[UB_STR_LAST];
  assign evt_item_done   = (st == ST_FIN) && !ctr_empty && desc.ctrl[CB_DONE_EN];
  assign evt_zero_len    = (st == ST_FIN) && ctr_empty;
  assign busy            = (st != ST_IDLE) && (st != ST_PAUSE);
  assign paused          = (st == ST_PAUSE);

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));
  a_r3_out_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)
                                && $stable(out_nbytes));
  a_r6_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_item_done && evt_zero_len));
  a_r5_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    evt_item_done |-> $past(out_valid && out_ready && out_last));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_item_done |=> !evt_item_done);
  a_r9_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !mem_rd_req && !out_valid);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !paused |-> !mem_rd_req && !out_valid && !evt_item_done && !evt_zero_len);
endmodule

// File: tb/tb_lldma_src_fetch.sv
`timescale 1ns/1ps
module tb_lldma_src_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0, cmd_restart = 1'b0;
  logic [31:0] base_addr = '0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_last;
  logic [2:0]  out_nbytes;
  logic        sb_str_start, sb_cipher_start, sb_str_last;
  logic        evt_item_done, evt_zero_len, busy, paused;

  always #2.5 clk = ~clk;

  lldma_src_fetch #(.ADDR_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_restart(cmd_restart),
    .base_addr(base_addr), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_nbytes(out_nbytes), .sb_str_start(sb_str_start),
    .sb_cipher_start(sb_cipher_start), .sb_str_last(sb_str_last),
    .evt_item_done(evt_item_done), .evt_zero_len(evt_zero_len),
    .busy(busy), .paused(paused)
  );

  typedef struct packed {
    logic [31:0] d;
    logic        lst;
    logic [2:0]  nb;
    logic [2:0]  sb;
  } beat_t;

  logic [31:0] mem [0:4095];
  beat_t exp_q[$];
  int checks = 0, fails = 0;
  int exp_done = 0, exp_zero = 0, got_done = 0, got_zero = 0;
  int reads = 0;
  int rdy_pct = 75;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // valid bytes of word w in an item of len bytes
  function automatic logic [2:0] bytes_in_word(input int len, input int w);
    int rem = len - 4*w;
    return (rem >= 4) ? 3'd4 : 3'(rem);
  endfunction

  task automatic put_item(input int da, input int sa, input int len, input logic [2:0] user,
                          input int nxt, input logic [2:0] ctrl, input bit expect_it);
    int nw = (len + 3) / 4;
    mem[da/4+0] = sa;
    mem[da/4+1] = len;
    mem[da/4+2] = ($urandom & 32'hFFFF_FFF8) | {29'd0, user};
    mem[da/4+3] = $urandom;
    mem[da/4+4] = nxt;
    mem[da/4+5] = ($urandom & 32'hFFFF_FFF8) | {29'd0, ctrl};
    for (int w = 0; w < nw; w++) begin
      mem[sa/4+w] = $urandom;
      if (expect_it)
        exp_q.push_back({mem[sa/4+w], (w == nw-1), bytes_in_word(len, w), user});
    end
    if (expect_it) begin
      if (len == 0) exp_zero++;
      else if (ctrl[0]) exp_done++;
    end
  endtask

  task automatic pulse_start(input logic [31:0] b);
    @(negedge clk); base_addr = b; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk); cmd_restart = 1'b1;
    @(negedge clk); cmd_restart = 1'b0;
  endtask

  task automatic run_until_idle(input string tag);
    int guard = 0;
    while ((busy || paused) && guard < 20000) begin
      if (paused) begin
        cmd_restart = 1'b1; @(negedge clk); cmd_restart = 1'b0;
      end else @(negedge clk);
      guard++;
    end
    chk(guard < 20000, tag, guard, 0);
  endtask

  task automatic check_end(input string tag);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    chk(got_done == exp_done, "R5 item-done count", got_done, exp_done);
    chk(got_zero == exp_zero, "R6 zero-length count", got_zero, exp_zero);
    chk(!busy && !paused && !mem_rd_req, "R7 idle after end-of-chain",
        {busy, paused, mem_rd_req}, 0);
  endtask

  task automatic rand_msg();
    int n = 1 + int'($urandom % 4);
    for (int k = 0; k < n; k++) begin
      bit fin = (k == n-1);
      int len = fin ? int'($urandom % 151) : 64 * (1 + int'($urandom % 3));
      logic [2:0] u = {fin, (k == 0), (k == 0)};
      logic [2:0] c = {fin ? 1'b0 : 1'($urandom % 2), fin, 1'($urandom % 2)};
      put_item(k*32, 32'h1000 + k*32'h400, len, u, (k+1)*32, c, 1'b1);
    end
    rdy_pct = 30 + int'($urandom % 71);
    pulse_start(32'h0);
    run_until_idle("R8 random chain watchdog");
    check_end("R8 R3 random chain stream");
  endtask

  // memory model: random latency, checks the request is held
  initial begin
    int lat = 0;
    bit pend = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        mem_rd_valid = 1'b0; pend = 0;
      end else if (mem_rd_req) begin
        if (pend) chk(mem_rd_addr == paddr, "R11 address held", mem_rd_addr, paddr);
        pend = 1; paddr = mem_rd_addr;
        if (lat == 0) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem[mem_rd_addr[13:2]];
          reads++;
          lat = int'($urandom % 3);
        end else lat--;
      end
    end
  end

  // output monitor and ready driver
  initial begin
    bit prev_final = 0;
    beat_t e, g;
    forever begin
      @(negedge clk);
      out_ready = (int'($urandom % 100) < rdy_pct);
      if (evt_item_done) begin
        got_done++;
        chk(prev_final, "R5 event one cycle after final word", 0, 1);
      end
      if (evt_zero_len) got_zero++;
      prev_final = 0;
      if (rst_n && out_valid && out_ready) begin
        g = {out_data, out_last, out_nbytes, {sb_str_last, sb_cipher_start, sb_str_start}};
        if (exp_q.size() == 0) chk(0, "R3 unexpected word", g, 0);
        else begin
          e = exp_q.pop_front();
          chk(g == e, "R3 R4 word", g, e);
        end
        prev_final = out_last;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int rd0;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !paused && !mem_rd_req && !out_valid && !evt_item_done && !evt_zero_len,
        "R1 reset state", {busy, paused, mem_rd_req, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !paused && !mem_rd_req && !out_valid, "R1 after release",
        {busy, paused, mem_rd_req, out_valid}, 0);

    // single final item, partial tail word, upper bits of marker/control ignored
    put_item(32'h0, 32'h1000, 70, 3'b101, 32'h0, 3'b011, 1'b1);
    pulse_start(32'h0);
    run_until_idle("R2 single item watchdog");
    check_end("R2 R3 R4 single item stream");

    // three-item chain followed without commands
    put_item(32'h100, 32'h1400, 64, 3'b011, 32'h180, 3'b001, 1'b1);
    put_item(32'h180, 32'h1800, 128, 3'b000, 32'h040, 3'b001, 1'b1);
    put_item(32'h040, 32'h1C00, 13, 3'b100, 32'h0, 3'b011, 1'b1);
    pulse_start(32'h100);
    run_until_idle("R8 chain watchdog");
    check_end("R8 three-item chain stream");

    // zero-length final item
    put_item(32'h200, 32'h2000, 64, 3'b001, 32'h240, 3'b001, 1'b1);
    put_item(32'h240, 32'h2400, 0, 3'b100, 32'h0, 3'b011, 1'b1);
    pulse_start(32'h200);
    run_until_idle("R6 zero-length watchdog");
    check_end("R6 zero-length item stream");

    // item-done-enable clear: no event
    put_item(32'h0, 32'h1000, 8, 3'b101, 32'h0, 3'b010, 1'b1);
    pulse_start(32'h0);
    run_until_idle("R5 no-event watchdog");
    check_end("R5 item-done disabled");

    // start and restart while busy are ignored
    put_item(32'h0, 32'h1000, 256, 3'b101, 32'h0, 3'b011, 1'b1);
    put_item(32'h40, 32'h2000, 64, 3'b111, 32'h0, 3'b011, 1'b0);
    pulse_start(32'h0);
    repeat (10) @(negedge clk);
    pulse_start(32'h40);
    pulse_restart();
    run_until_idle("R10 busy watchdog");
    check_end("R10 commands while busy ignored");

    // restart while idle is ignored
    rd0 = reads;
    pulse_restart();
    repeat (10) @(negedge clk);
    chk(reads == rd0 && !busy && !paused, "R10 restart in idle ignored", reads - rd0, 0);

    // pause, rewrite the same descriptor, restart
    rdy_pct = 75;
    put_item(32'h80, 32'h1000, 64, 3'b011, 32'h80, 3'b101, 1'b1);
    pulse_start(32'h80);
    begin
      int guard = 0;
      while (!paused && guard < 5000) begin @(negedge clk); guard++; end
      chk(paused == 1'b1, "R9 pause reached", paused, 1);
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 paused item fully streamed", exp_q.size(), 0);
    rd0 = reads;
    repeat (15) @(negedge clk);
    chk(paused && reads == rd0 && !out_valid, "R9 paused holds", reads - rd0, 0);
    pulse_start(32'h0);
    repeat (5) @(negedge clk);
    chk(paused && reads == rd0, "R10 start while paused ignored", reads - rd0, 0);
    put_item(32'h80, 32'h2000, 30, 3'b100, 32'h0, 3'b011, 1'b1);
    pulse_restart();
    run_until_idle("R9 restart watchdog");
    check_end("R9 restart continues message");

    // randomized chains with pauses, stalls and latencies
    for (int m = 0; m < 20; m++) rand_msg();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule